// File: doc/BRIEF.md
# Pulse-Swallow Divide Control

This block runs the two down-counters that steer an external prescaler with a divide-by-64 and a divide-by-65 setting. It runs on the prescaler's output clock. Each output period lasts N of those clocks. For the first A clocks of the period it asks the prescaler for 65, and for the rest it asks for 64. The input-side divide ratio therefore comes to 65·A + 64·(N − A), which equals 64·N + A. At the end of each period it sends a single-cycle pulse to the phase comparator.

New ratios arrive from an outside holding register. A one-cycle transfer strobe captures them into a shadow stage. The same strobe can also serve the reference divider, so every divider picks up its new value at the same event. The shadow moves A and N into the active pair in one step, and never in the cycle where the counters reload. The reload therefore always sees a matched pair of values. A pair that cannot form a valid period is refused, and a sticky error output is raised.

Top module: `pswallow_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until the first transfer, mod_sel = 0, div_pulse = 0 and cfg_err = 0. The divider runs with N = 4095 and A = 0, so the period is 4095 clocks, all with mod_sel = 0.
- R2: div_pulse is high for exactly one clock per period. Consecutive pulses are N clocks apart, where N is the active main count. The interval counts the clocks after one pulse up to and including the next.
- R3: Within each period, mod_sel = 1 (select 65) for exactly the first A clocks and 0 (select 64) for the remaining N − A clocks. The period's input-side length, Σ(mod_sel ? 65 : 64), is 64·N + A.
- R4: With A = 0, mod_sel never rises in the period. With A = N, mod_sel stays 1 for the whole period, including the pulse clock.
- R5: A pair strobed by xfer while the counters are at least three clocks from their next reload governs every period from the next reload on. The period already running finishes with the old pair.
- R6: The active A and N change together, and never in the clock where div_pulse is high. A pair strobed in the clock just before a pulse first governs the period that starts after the second following pulse.
- R7: A strobed pair with N < A or N < 2 is refused. cfg_err goes to 1 on the clock after the strobe and stays 1 until reset. The active pair is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer | input | 1 | One-cycle strobe that captures hold_a and hold_n |
| hold_a | input | A_W (6) | Swallow count from the holding register |
| hold_n | input | N_W (12) | Main count from the holding register |
| mod_sel | output | 1 | Prescaler modulus select: 1 = 65, 0 = 64 |
| div_pulse | output | 1 | One-clock pulse at the end of each period |
| cfg_err | output | 1 | Sticky flag for a refused pair |

## Verification
The divider is exercised with several kinds of pairs:
- The reset pair, in which A = 0 keeps the whole period at 64.
- Pairs with A = N, which hold 65 through the pulse clock.
- A pair with A at its 6-bit maximum.
- Random legal pairs.

For each period, the clock count and the weighted 64/65 sum are measured separately. This tells a wrong main count apart from a wrong swallow count. Strobes are placed both early in a period and in the clock before a pulse. The two placements differ in which period first uses the new pair, and that exposes when the update is applied relative to the reload. Refused pairs, one with N < A and one with N = 1, show that the running ratio is left unchanged and that the error flag latches.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  typedef enum logic {
    SEL_DIV_LO = 1'b0,
    SEL_DIV_HI = 1'b1
  } mod_sel_e;

  // A pair is usable when the swallow part fits inside the period and the
  // period is at least two clocks long.
  function automatic logic pair_ok(input int unsigned a, input int unsigned n);
    return (n >= a) && (n >= 32'd2);
  endfunction

  // Input-side length of one period for a prescaler pair lo / lo+1.
  function automatic int unsigned period_weight(input int unsigned a,
                                                input int unsigned n,
                                                input int unsigned lo);
    return a * (lo + 32'd1) + (n - a) * lo;
  endfunction

endpackage

// File: rtl/pswallow_shadow.sv
module pswallow_shadow
  import pswallow_pkg::*;
#(
  parameter int unsigned A_W = 6,
  parameter int unsigned N_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           xfer,
  input  logic [A_W-1:0] hold_a,
  input  logic [N_W-1:0] hold_n,
  input  logic           reload,
  output logic [A_W-1:0] act_a,
  output logic [N_W-1:0] act_n,
  output logic           pend,
  output logic           apply,
  output logic           cfg_err
);

  localparam logic [N_W-1:0] N_RST = {N_W{1'b1}};
  localparam logic [A_W-1:0] A_RST = '0;

  logic [A_W-1:0] shd_a;
  logic [N_W-1:0] shd_n;
  logic           accept;
  logic           refuse;

  assign accept = xfer && pair_ok(32'(hold_a), 32'(hold_n));
  assign refuse = xfer && !accept;
  // Never move the pair while the counters are taking their reload.
  assign apply  = pend && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_a <= A_RST;
      shd_n <= N_RST;
    end else if (accept) begin
      shd_a <= hold_a;
      shd_n <= hold_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (accept) begin
      pend <= 1'b1;
    end else if (apply) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a <= A_RST;
      act_n <= N_RST;
    end else if (apply) begin
      act_a <= shd_a;
      act_n <= shd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_err <= 1'b0;
    end else if (refuse) begin
      cfg_err <= 1'b1;
    end
  end

endmodule

// File: rtl/pswallow_counters.sv
module pswallow_counters
  import pswallow_pkg::*;
#(
  parameter int unsigned A_W = 6,
  parameter int unsigned N_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] act_a,
  input  logic [N_W-1:0] act_n,
  output logic           reload,
  output logic           mod_sel,
  output logic           div_pulse
);

  localparam logic [N_W-1:0] N_START = {N_W{1'b1}} - N_W'(1);

  logic [N_W-1:0] n_cnt;
  logic [A_W-1:0] a_cnt;
  logic           swallow_on;
  mod_sel_e       sel;

  assign reload     = (n_cnt == '0);
  assign swallow_on = (a_cnt != '0);
  assign sel        = swallow_on ? SEL_DIV_HI : SEL_DIV_LO;
  assign mod_sel    = (sel == SEL_DIV_HI);
  assign div_pulse  = reload;

  // Main counter: N-1 down to 0, with 0 marking the last clock of the period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_cnt <= N_START;
    end else if (reload) begin
      n_cnt <= act_n - N_W'(1);
    end else begin
      n_cnt <= n_cnt - N_W'(1);
    end
  end

  // Swallow counter: loads with the main counter, runs down to 0 and waits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt <= '0;
    end else if (reload) begin
      a_cnt <= act_a;
    end else if (swallow_on) begin
      a_cnt <= a_cnt - A_W'(1);
    end
  end

endmodule

// File: rtl/pswallow_ctrl.sv
module pswallow_ctrl
  import pswallow_pkg::*;
#(
  parameter int unsigned A_W = 6,
  parameter int unsigned N_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           xfer,
  input  logic [A_W-1:0] hold_a,
  input  logic [N_W-1:0] hold_n,
  output logic           mod_sel,
  output logic           div_pulse,
  output logic           cfg_err
);

  logic [A_W-1:0] act_a;
  logic [N_W-1:0] act_n;
  logic           reload;
  logic           pend;
  logic           apply;

  pswallow_shadow #(.A_W(A_W), .N_W(N_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .xfer    (xfer),
    .hold_a  (hold_a),
    .hold_n  (hold_n),
    .reload  (reload),
    .act_a   (act_a),
    .act_n   (act_n),
    .pend    (pend),
    .apply   (apply),
    .cfg_err (cfg_err)
  );

  pswallow_counters #(.A_W(A_W), .N_W(N_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_a     (act_a),
    .act_n     (act_n),
    .reload    (reload),
    .mod_sel   (mod_sel),
    .div_pulse (div_pulse)
  );

endmodule

// File: rtl/pswallow_ctrl_chk.sv
module pswallow_ctrl_chk
  import pswallow_pkg::*;
#(
  parameter int unsigned A_W = 6,
  parameter int unsigned N_W = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           xfer,
  input logic [A_W-1:0] hold_a,
  input logic [N_W-1:0] hold_n,
  input logic           mod_sel,
  input logic           div_pulse,
  input logic           cfg_err,
  input logic           reload,
  input logic           pend,
  input logic [A_W-1:0] act_a,
  input logic [N_W-1:0] act_n
);

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  p_swallow_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_sel && !div_pulse) |=> !mod_sel);

  p_pair_held_in_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> ($stable(act_a) && $stable(act_n)));

  p_pending_survives_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && reload) |=> pend);

  p_refuse_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !pair_ok(32'(hold_a), 32'(hold_n))) |=> cfg_err);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  p_refuse_keeps_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !pair_ok(32'(hold_a), 32'(hold_n)) && !pend)
      |=> ($stable(act_a) && $stable(act_n)));

endmodule

bind pswallow_ctrl pswallow_ctrl_chk #(.A_W(A_W), .N_W(N_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xfer      (xfer),
  .hold_a    (hold_a),
  .hold_n    (hold_n),
  .mod_sel   (mod_sel),
  .div_pulse (div_pulse),
  .cfg_err   (cfg_err),
  .reload    (reload),
  .pend      (pend),
  .act_a     (act_a),
  .act_n     (act_n)
);

// File: tb/pswallow_ctrl_tb.sv
module pswallow_ctrl_tb;

  localparam int A_W = 6;
  localparam int N_W = 12;
  localparam int LO  = 64;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           xfer = 1'b0;
  logic [A_W-1:0] hold_a = '0;
  logic [N_W-1:0] hold_n = '0;
  logic           mod_sel;
  logic           div_pulse;
  logic           cfg_err;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  int exp_a_q[$];
  int exp_n_q[$];
  bit skip = 1'b1;
  int cur_a = 0;
  int cur_n = 4095;
  int mon_cnt = 0;
  int mon_w = 0;

  always #5 clk = ~clk;

  pswallow_ctrl #(.A_W(A_W), .N_W(N_W)) u_dut (
    .clk (clk), .rst_n (rst_n), .xfer (xfer), .hold_a (hold_a), .hold_n (hold_n),
    .mod_sel (mod_sel), .div_pulse (div_pulse), .cfg_err (cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // Monitor: measure each period and compare against the next queued pair.
  always @(negedge clk) begin
    if (rst_n) begin
      mon_cnt++;
      mon_w += mod_sel ? (LO + 1) : LO;
      if (div_pulse) begin
        if (skip) begin
          skip = 1'b0;
        end else if (exp_n_q.size() > 0) begin
          int ea;
          int en;
          ea = exp_a_q.pop_front();
          en = exp_n_q.pop_front();
          check(mon_cnt == en, "R2 period clocks", mon_cnt, en);
          check(mon_w == LO * en + ea, "R3 weighted length", mon_w, LO * en + ea);
        end
        mon_cnt = 0;
        mon_w = 0;
      end
    end
  end

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  task automatic push_pair(input int a, input int n, input int k);
    for (int i = 0; i < k; i++) begin
      exp_a_q.push_back(a);
      exp_n_q.push_back(n);
    end
  endtask

  // Driver: strobe a pair early in a period or in the clock before a pulse.
  task automatic program_pair(input int a, input int n, input bit late, input int k);
    bit legal;
    legal = (n >= a) && (n >= 2);
    wait_pulse();
    if (late) repeat (cur_n - 1) @(negedge clk);
    else repeat (2) @(negedge clk);
    hold_a = A_W'(a);
    hold_n = N_W'(n);
    xfer = 1'b1;
    skip = 1'b1;
    if (legal) begin
      if (late) push_pair(cur_a, cur_n, 1);  // R6: one more old period
      push_pair(a, n, k);                    // R5
      cur_a = a;
      cur_n = n;
    end else begin
      push_pair(cur_a, cur_n, k);            // R7: ratio unchanged
    end
    @(negedge clk);
    xfer = 1'b0;
    if (!legal) check(cfg_err == 1'b1, "R7 err set", int'(cfg_err), 1);
    wait (exp_n_q.size() == 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(mod_sel == 1'b0, "R1 mod in reset", int'(mod_sel), 0);
    check(div_pulse == 1'b0, "R1 pulse in reset", int'(div_pulse), 0);
    check(cfg_err == 1'b0, "R1 err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mod_sel == 1'b0, "R1 mod after reset", int'(mod_sel), 0);
    push_pair(0, 4095, 1);                   // R1 default ratio
    wait (exp_n_q.size() == 0);
    check(cfg_err == 1'b0, "R1 err idle", int'(cfg_err), 0);

    program_pair(5, 20, 1'b0, 3);            // R3, R5
    program_pair(0, 9, 1'b0, 2);             // R4 no swallow
    program_pair(9, 9, 1'b0, 2);             // R4 swallow through whole period
    program_pair(63, 70, 1'b0, 2);           // R3 maximum swallow
    program_pair(3, 12, 1'b1, 2);            // R6 late strobe
    program_pair(4, 30, 1'b1, 1);            // R6 late strobe again
    for (int i = 0; i < 6; i++) begin
      int ra;
      int rn;
      ra = int'($urandom_range(0, 63));
      rn = ra + int'($urandom_range(0, 200));
      if (rn < 4) rn = 4;
      program_pair(ra, rn, 1'b0, 2);         // R3 random legal pairs
    end
    program_pair(10, 5, 1'b0, 2);            // R7 N < A
    program_pair(0, 1, 1'b0, 1);             // R7 N < 2
    program_pair(6, 40, 1'b0, 2);            // R7 flag stays, legal pair still works
    check(cfg_err == 1'b1, "R7 err sticky", int'(cfg_err), 1);
    finish_run();
  end

endmodule